// File: doc/BRIEF.md
# Prescaled Capture Timer

This block is a 16-bit free-running counter shared by two input-capture channels. The counter advances on a timer tick. A 3-bit source code picks where the tick comes from. Seven codes select a power-of-two division of the bus clock. The eighth code selects the rising edges of an external clock pin, which is first passed through a two-flop synchroniser.

Each channel passes its capture pin through a two-flop synchroniser and then an edge detector. The detector can be set to rising edges, falling edges, either edge, or off. On an active edge the channel copies the counter into its 16-bit capture register and raises its flag. When its enable bit is set, it also drives an interrupt request.

Software reaches the block through a byte-wide register port. The port holds one control byte, one status/control byte per channel, and each capture value split into a high byte and a low byte. Reading the high byte freezes the low byte, so that software always reads a coherent 16-bit pair.

Top module: `capture_timer`

## Requirements
- R1: After reset, every readable byte reads 0x00 and both interrupt requests are low.
- R2: The prescaler is a 6-bit counter that counts bus clocks from reset and never stops.
  - With source code n in 0..6, a tick happens on a bus clock when the low n bits of the prescaler are all ones, so one tick every 2^n clocks.
  - The counter rises by one on each tick and wraps from 0xFFFF to 0x0000.
- R3: Source code 7 makes each rising edge of the external clock pin, seen after its two-flop synchroniser, one tick.
- R4: Bits [3:2] of a channel's status/control byte select the active edge: 00 off, 01 rising, 10 falling, 11 either.
  - On an active edge the capture register takes the counter value present after the second rising bus-clock edge that follows the pin change.
  - An inactive edge leaves the capture register unchanged.
- R5: A capture sets the channel flag (bit 7 of its status/control byte). A flag that is already set stays set when a new capture arrives.
- R6: Writing the status/control byte with bit 7 = 0 clears the flag, and writing bit 7 = 1 leaves the flag as it was. When a capture and a clearing write fall in the same cycle, the flag ends up set.
- R7: A channel's interrupt request is high exactly when both its flag and its enable bit (bit 6) are set.
- R8: Bits 5, 4, 1 and 0 of each status/control byte are storage bits that read back what was written. The exception is bit 5 of channel 1, which always reads 0.
- R9: The byte addresses are laid out as follows:
  - Address 0 is the control byte. Bits [2:0] hold the source code, other bits read 0, and writes to them are ignored.
  - Channel c has its status/control byte at 1+3c, its capture high byte at 2+3c and its capture low byte at 3+3c.
  - Address 7 reads 0x00.
- R10: A read of a channel's capture high byte freezes that channel's low byte until the low byte is read. A capture that arrives in that window is still stored, and it shows on the next high/low read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle (triggers read side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| ext_clk_pin | input | 1 | External timer clock pin |
| cap_pin | input | 2 | Capture input pin per channel |
| irq | output | 2 | Interrupt request per channel |

## Verification
A counter that drifts from the tick rule shows up in the very next capture value, because every capture is compared with an independent count of bus clocks and source code. A wrong synchroniser depth moves each captured value by one tick at the first capture. A flag that is lost or set when it should not be shows in the status byte and in the interrupt pin in the cycle after the event. A broken freeze on the low byte appears only on a low-byte read that follows a capture landing between the two halves, and the bench creates that case on purpose.

// File: rtl/captmr_pkg.sv
package captmr_pkg;

  // Status/control byte bit positions (software-visible layout)
  localparam int SC_FLAG = 7;
  localparam int SC_IE   = 6;
  localparam int SC_MSB  = 5;
  localparam int SC_MSA  = 4;
  localparam int SC_ELSB = 3;
  localparam int SC_ELSA = 2;
  localparam int SC_TOV  = 1;
  localparam int SC_MAX  = 0;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  // Active-edge decision from synchronised current/previous level
  function automatic logic edge_hit(input logic cur, input logic prev, input edge_sel_e sel);
    return (sel[0] & cur & ~prev) | (sel[1] & ~cur & prev);
  endfunction

endpackage

// File: rtl/ctp_clock_gen.sv
module ctp_clock_gen #(
  parameter int PS_W = 3,
  parameter int SYNC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PS_W-1:0] sel,
  input  logic            ext_pin,
  output logic            tick
);
  localparam int EXT_CODE = (1 << PS_W) - 1;
  localparam int PRE_W    = (EXT_CODE > 1) ? EXT_CODE - 1 : 1;

  logic [PRE_W-1:0] pre_q;
  logic [SYNC:0]    ext_sh;
  logic             ext_rise;
  logic             div_hit;

  // Tick when the low `code` bits of the prescaler are all ones
  function automatic logic div_tick(input logic [PRE_W-1:0] pre, input logic [PS_W-1:0] code);
    logic [PRE_W-1:0] mask;
    mask = ~({PRE_W{1'b1}} << code);
    return (pre & mask) == mask;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q  <= '0;
      ext_sh <= '0;
    end else begin
      pre_q  <= pre_q + PRE_W'(1);
      ext_sh <= {ext_sh[SYNC-1:0], ext_pin};
    end
  end

  assign ext_rise = ext_sh[SYNC-1] & ~ext_sh[SYNC];
  assign div_hit  = div_tick(pre_q, sel);
  assign tick     = (sel == PS_W'(EXT_CODE)) ? ext_rise : div_hit;

endmodule

// File: rtl/ctp_edge_det.sv
module ctp_edge_det
  import captmr_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] sel,
  output logic       hit
);
  logic [SYNC:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC-1:0], pin};
  end

  assign hit = edge_hit(sh[SYNC-1], sh[SYNC], edge_sel_e'(sel));

endmodule

// File: rtl/ctp_channel.sv
module ctp_channel
  import captmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int SYNC    = 2,
  parameter bit HAS_MSB = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             pin,
  input  logic             sc_we,
  input  logic [7:0]       wdata,
  input  logic             hi_rd,
  input  logic             lo_rd,
  output logic [7:0]       sc_byte,
  output logic [CNT_W-1:0] cap_val,
  output logic [7:0]       lo_byte,
  output logic             cap_evt,
  output logic             clr_req,
  output logic             flag,
  output logic             irq
);
  logic             ie_q, msb_q, msa_q, tov_q, max_q;
  logic [1:0]       els_q;
  logic [CNT_W-1:0] cap_q;
  logic             lock_q;
  logic [7:0]       hold_q;

  ctp_edge_det #(.SYNC(SYNC)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(pin), .sel(els_q), .hit(cap_evt)
  );

  assign clr_req = sc_we & ~wdata[SC_FLAG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      ie_q  <= 1'b0;
      msb_q <= 1'b0;
      msa_q <= 1'b0;
      els_q <= 2'b00;
      tov_q <= 1'b0;
      max_q <= 1'b0;
      cap_q <= '0;
    end else begin
      if (cap_evt)      flag <= 1'b1;
      else if (clr_req) flag <= 1'b0;
      if (cap_evt) cap_q <= cnt;
      if (sc_we) begin
        ie_q  <= wdata[SC_IE];
        msb_q <= HAS_MSB ? wdata[SC_MSB] : 1'b0;
        msa_q <= wdata[SC_MSA];
        els_q <= {wdata[SC_ELSB], wdata[SC_ELSA]};
        tov_q <= wdata[SC_TOV];
        max_q <= wdata[SC_MAX];
      end
    end
  end

  // Coherent 16-bit read: high-byte read freezes the low byte
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      hold_q <= '0;
    end else if (hi_rd) begin
      lock_q <= 1'b1;
      hold_q <= cap_q[7:0];
    end else if (lo_rd) begin
      lock_q <= 1'b0;
    end
  end

  assign sc_byte = {flag, ie_q, msb_q, msa_q, els_q, tov_q, max_q};
  assign cap_val = cap_q;
  assign lo_byte = lock_q ? hold_q : cap_q[7:0];
  assign irq     = flag & ie_q;

endmodule

// File: rtl/capture_timer.sv
module capture_timer #(
  parameter int NCH    = 2,
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3,
  parameter int ADDR_W = 3,
  parameter int SYNC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              ext_clk_pin,
  input  logic [NCH-1:0]    cap_pin,
  output logic [NCH-1:0]    irq
);
  localparam int CTRL_ADDR = 0;
  localparam int CH_BASE   = 1;
  localparam int CH_STRIDE = 3;

  logic [PS_W-1:0]      ps_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 cnt_tick;
  logic [NCH-1:0]       cap_evt;
  logic [NCH-1:0]       clr_req;
  logic [NCH-1:0]       flag_vec;
  logic [NCH*CNT_W-1:0] cap_flat;
  logic [7:0]           sc_byte [NCH];
  logic [7:0]           lo_byte [NCH];

  ctp_clock_gen #(.PS_W(PS_W), .SYNC(SYNC)) u_clk_gen (
    .clk(clk), .rst_n(rst_n), .sel(ps_q), .ext_pin(ext_clk_pin), .tick(cnt_tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (bus_wr && bus_addr == ADDR_W'(CTRL_ADDR)) ps_q <= bus_wdata[PS_W-1:0];
      if (cnt_tick) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int BASE = CH_BASE + CH_STRIDE * g;
    ctp_channel #(.CNT_W(CNT_W), .SYNC(SYNC), .HAS_MSB(g == 0)) u_ch (
      .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .pin(cap_pin[g]),
      .sc_we(bus_wr && bus_addr == ADDR_W'(BASE)),
      .wdata(bus_wdata),
      .hi_rd(bus_rd && bus_addr == ADDR_W'(BASE + 1)),
      .lo_rd(bus_rd && bus_addr == ADDR_W'(BASE + 2)),
      .sc_byte(sc_byte[g]),
      .cap_val(cap_flat[g*CNT_W +: CNT_W]),
      .lo_byte(lo_byte[g]),
      .cap_evt(cap_evt[g]),
      .clr_req(clr_req[g]),
      .flag(flag_vec[g]),
      .irq(irq[g])
    );
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_addr == ADDR_W'(CTRL_ADDR)) bus_rdata = {{(8-PS_W){1'b0}}, ps_q};
    for (int c = 0; c < NCH; c++) begin
      if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE*c))     bus_rdata = sc_byte[c];
      if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE*c + 1)) bus_rdata = cap_flat[c*CNT_W + CNT_W - 8 +: 8];
      if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE*c + 2)) bus_rdata = lo_byte[c];
    end
  end

endmodule

// File: rtl/capture_timer_chk.sv
module capture_timer_chk #(
  parameter int NCH   = 2,
  parameter int CNT_W = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [CNT_W-1:0]     cnt,
  input logic                 tick,
  input logic [NCH-1:0]       cap_evt,
  input logic [NCH-1:0]       clr_req,
  input logic [NCH-1:0]       flags,
  input logic [NCH*CNT_W-1:0] caps
);
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt == $past(cnt) + CNT_W'(1));
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R4
    cap_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt[c] |=> caps[c*CNT_W +: CNT_W] == $past(cnt));
    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt[c] |=> flags[c]);
    // R6
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[c] && !clr_req[c]) |=> flags[c]);
    // R4
    cap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_evt[c] |=> $stable(caps[c*CNT_W +: CNT_W]));
  end

endmodule

bind capture_timer capture_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .tick(cnt_tick),
  .cap_evt(cap_evt), .clr_req(clr_req), .flags(flag_vec), .caps(cap_flat)
);

// File: tb/tb_capture_timer.sv
`timescale 1ns/1ps
module tb_capture_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ext_pin = 1'b0;
  logic [1:0] pin = '0;
  logic [1:0] irq;

  int vectors = 0, fails = 0;
  bit done = 0;

  // Reference model of prescaler and counter (from R2)
  int pre_ref = 0, cnt_ref = 0, ps_ref = 0;

  always #5 clk = ~clk;

  capture_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata), .ext_clk_pin(ext_pin),
    .cap_pin(pin), .irq(irq)
  );

  function automatic bit ref_tick(int pre, int code);
    return code != 7 && ((pre + 1) % (1 << code)) == 0;
  endfunction

  function automatic bit ref_active(bit level_now, int els);
    return level_now ? els[0] : els[1];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      pre_ref <= 0; cnt_ref <= 0; ps_ref <= 0;
    end else begin
      pre_ref <= (pre_ref + 1) % 64;
      if (ref_tick(pre_ref, ps_ref)) cnt_ref <= (cnt_ref + 1) % 65536;
      if (wr && addr == 3'd0) ps_ref <= int'(wdata[2:0]);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input int d);
    @(negedge clk); addr = 3'(a); wdata = 8'(d); wr = 1'b1;
    @(posedge clk); #1 wr = 1'b0;
  endtask

  task automatic bus_read(input int a, output int d);
    @(negedge clk); addr = 3'(a); rd = 1'b1; #1 d = int'(rdata);
    @(posedge clk); #1 rd = 1'b0;
  endtask

  task automatic read16(input int ch, output int v);
    int h, l;
    bus_read(2 + 3*ch, h);
    bus_read(3 + 3*ch, l);
    v = (h << 8) | l;
  endtask

  // Drive a pin level and return the counter value a capture would take (R4)
  task automatic fire(input int ch, input bit lvl, output int exp);
    @(negedge clk); pin[ch] = lvl;
    @(posedge clk); @(posedge clk);
    @(negedge clk); exp = cnt_ref;
    @(posedge clk); @(negedge clk);
  endtask

  function automatic int sc_val(bit ie, int els);
    return (int'(ie) << 6) | (els << 2);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; vectors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int d, v, old, exp, e2;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 / R9: reset values and unmapped address
    for (int a = 0; a < 8; a++) begin
      bus_read(a, d);
      check(d == 0, (a == 7) ? "R9" : "R1", d, 0);
    end
    check(irq == 2'b00, "R1", irq, 0);

    // R8: storage bits; channel 1 bit 5 reserved; R6 flag write 1 ignored
    bus_write(1, 8'hB3); bus_read(1, d); check(d == 8'h33, "R8", d, 8'h33);
    bus_write(4, 8'hB3); bus_read(4, d); check(d == 8'h13, "R8", d, 8'h13);
    bus_write(1, 0); bus_write(4, 0);

    // R9: upper control bits ignored
    bus_write(0, 8'hF5); bus_read(0, d); check(d == 5, "R9", d, 5);

    // Random captures across prescale codes and edge selects (R2, R4, R5, R7)
    for (int i = 0; i < 48; i++) begin
      int ch, ps, els;
      bit ie, lvl, act;
      ch = $urandom % 2; ps = $urandom % 7; els = $urandom % 4; ie = $urandom % 2;
      bus_write(0, (($urandom % 32) << 3) | ps);
      bus_write(1 + 3*ch, sc_val(ie, els));
      read16(ch, old);
      repeat ($urandom % 8) @(posedge clk);
      lvl = ~pin[ch];
      fire(ch, lvl, exp);
      act = ref_active(lvl, els);
      read16(ch, v);
      check(v == (act ? exp : old), act ? "R2" : "R4", v, act ? exp : old);
      bus_read(1 + 3*ch, d);
      check(d[7] == act, "R5", d, act);
      check(irq[ch] == (act & ie), "R7", irq, act & ie);
    end

    // R5: flag stays set on a second capture; R6: write of 1 keeps, 0 clears
    bus_write(0, 0);
    bus_write(1, sc_val(1, 3));
    fire(0, ~pin[0], exp);
    fire(0, ~pin[0], exp);
    read16(0, v); check(v == exp, "R5", v, exp);
    bus_read(1, d); check(d[7] == 1'b1, "R5", d, 8'h80);
    bus_write(1, 8'h80 | sc_val(1, 3));
    bus_read(1, d); check(d[7] == 1'b1, "R6", d, 8'h80);
    check(irq[0] == 1'b1, "R7", irq, 1);
    bus_write(1, sc_val(1, 3));
    bus_read(1, d); check(d[7] == 1'b0, "R6", d, 0);
    check(irq[0] == 1'b0, "R7", irq, 0);

    // R6: capture and clearing write in the same cycle -> flag set
    @(negedge clk); pin[0] = ~pin[0];
    @(posedge clk); @(posedge clk);
    @(negedge clk); addr = 3'd1; wdata = 8'(sc_val(0, 3)); wr = 1'b1;
    @(posedge clk); #1 wr = 1'b0;
    bus_read(1, d); check(d[7] == 1'b1, "R6", d, 8'h80);

    // R10: coherent read across a capture in the window
    bus_write(0, 1);
    bus_write(4, sc_val(0, 3));
    fire(1, ~pin[1], exp);
    read16(1, old);
    bus_read(5, d); check(d == (old >> 8), "R10", d, old >> 8);
    repeat (5) @(posedge clk);
    fire(1, ~pin[1], e2);
    bus_read(6, d); check(d == (old & 8'hFF), "R10", d, old & 8'hFF);
    read16(1, v); check(v == e2, "R10", v, e2);

    // R2: counter wrap at full speed
    bus_write(0, 0);
    repeat (65536 + 17) @(posedge clk);
    fire(0, ~pin[0], exp);
    read16(0, v); check(v == exp, "R2", v, exp);

    // R3: external clock pin as tick source
    bus_write(0, 7);
    bus_write(1, sc_val(0, 1));
    @(negedge clk); pin[0] = 1'b0; repeat (4) @(negedge clk);
    fire(0, 1'b1, exp);
    read16(0, old);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); ext_pin = 1'b1; repeat (3) @(negedge clk);
      ext_pin = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    pin[0] = 1'b0; repeat (4) @(negedge clk);
    fire(0, 1'b1, exp);
    read16(0, v);
    check(((v - old) & 16'hFFFF) == 5, "R3", (v - old) & 16'hFFFF, 5);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule